// File: doc/BRIEF.md
# Power-Good Delay and Reset Fan-Out

This block generates a delayed power-good indication for the platform and distributes a single host reset to several buffered reset lines. Power-good goes high only after both the standby-supply-ok flag and the power-supply-good input have stayed high for a programmable wait. The standby-supply-ok flag is the digital result of the standby rail crossing 2.8 V. The wait is counted in millisecond ticks supplied from outside. It is the sum of a main delay and an optional extra delay, and each is picked from its own menu of four values by configuration inputs.

A separate reset-control line can be enabled. When enabled, it follows either the delayed power-good or reset outputs 4 and 5, as chosen by a select bit. When it is not enabled, it stays high. All reset outputs are active low. The parameter `UNIT` is the number of ticks in 100 ms. It is 100 by default, so one tick stands for one millisecond.

Top module: `pwrgood_rst_fanout`

## Requirements
- R1: Each of the five outputs `rst_out_n[4:0]` carries the level of `host_rst_n` in the same cycle.
- R2: `pg_out` is 0 during reset, and it is 0 whenever it has not yet finished counting since `stby_ok` and `psu_good` were both last seen high.
- R3: The main delay `main_sel` is coded as follows: 2'b00 gives 4·UNIT ticks (the value used when the register is reset), 2'b01 gives 1·UNIT, 2'b10 gives 2·UNIT and 2'b11 gives 3·UNIT.
- R4: The extra delay `extra_sel` is coded as follows: 2'b00 adds 0 ticks, 2'b01 adds 1·UNIT, 2'b10 adds 2·UNIT and 2'b11 adds 4·UNIT. It is added to the main delay.
- R5: `pg_out` rises on the clock edge at which the Nth `tick_ms` is sampled with both inputs high, where N is the total delay. Cycles without a tick do not advance the count.
- R6: If `stby_ok` or `psu_good` is sampled low, `pg_out` is 0 after that clock edge and the count returns to zero. A later attempt needs the full delay again.
- R7: The delay total is captured while the inputs are not both good. Changing `main_sel` or `extra_sel` during a count does not alter that count. The new total applies to the next attempt.
- R8: With `rc_en` = 0, `rc_out_n` is 1.
- R9: With `rc_en` = 1, `rc_out_n` equals `pg_out` when `rc_src` = 0. It equals the level of reset outputs 4 and 5 when `rc_src` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_ok | input | 1 | Standby rail above threshold |
| psu_good | input | 1 | Power supply good |
| host_rst_n | input | 1 | Host reset, active low |
| tick_ms | input | 1 | One-cycle millisecond tick |
| main_sel | input | 2 | Main delay select |
| extra_sel | input | 2 | Extra delay select |
| rc_en | input | 1 | Reset-control output enable |
| rc_src | input | 1 | Reset-control source: 0 power-good, 1 resets 4/5 |
| pg_out | output | 1 | Delayed power-good |
| rst_out_n | output | 5 | Buffered host reset copies, active low |
| rc_out_n | output | 1 | Reset-control output, active low |

## Verification
The bench measures the exact edge at which power-good rises for every main and extra setting. A delay table with wrong entries, or a compare that is off by one, would move that edge. Tick gaps are inserted partway through a count, so a design that counts clocks rather than ticks would assert early. Supply drops are applied both after assertion and during a count; a design that keeps its partial count would come back too soon. Settings are changed during a count, and a design that reads them live would assert at the new total rather than the captured one.

// File: rtl/pwrgood_rst_fanout.sv
module pwrgood_rst_fanout #(
  parameter int UNIT = 100,
  parameter int NRST = 5,
  localparam int MAXT = 8 * UNIT,
  localparam int CW = $clog2(MAXT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stby_ok,
  input  logic            psu_good,
  input  logic            host_rst_n,
  input  logic            tick_ms,
  input  logic [1:0]      main_sel,
  input  logic [1:0]      extra_sel,
  input  logic            rc_en,
  input  logic            rc_src,
  output logic            pg_out,
  output logic [NRST-1:0] rst_out_n,
  output logic            rc_out_n
);

  logic          good;
  logic [CW-1:0] main_t, extra_t, total, tot_q, cnt;

  assign good = stby_ok & psu_good;

  always_comb begin
    case (main_sel)
      2'b01:   main_t = CW'(UNIT);
      2'b10:   main_t = CW'(2 * UNIT);
      2'b11:   main_t = CW'(3 * UNIT);
      default: main_t = CW'(4 * UNIT);
    endcase
    case (extra_sel)
      2'b01:   extra_t = CW'(UNIT);
      2'b10:   extra_t = CW'(2 * UNIT);
      2'b11:   extra_t = CW'(4 * UNIT);
      default: extra_t = '0;
    endcase
    total = main_t + extra_t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tot_q  <= CW'(4 * UNIT);
      pg_out <= 1'b0;
    end else if (!good) begin
      cnt    <= '0;
      tot_q  <= total;
      pg_out <= 1'b0;
    end else if (!pg_out && tick_ms) begin
      if (cnt + CW'(1) >= tot_q) pg_out <= 1'b1;
      else cnt <= cnt + CW'(1);
    end
  end

  for (genvar i = 0; i < NRST; i++) begin : g_fan
    assign rst_out_n[i] = host_rst_n;
  end

  assign rc_out_n = !rc_en ? 1'b1 :
                    rc_src ? (rst_out_n[NRST-1] & rst_out_n[NRST-2]) : pg_out;

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !good |=> !pg_out);
  p_needs_inputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_out) |-> $past(good));
  p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_out) |-> $past(tick_ms));
  p_hold_total_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (good && $past(good)) |-> $stable(tot_q));
  p_rc_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_en |-> rc_out_n);
  p_rc_pg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_en && !rc_src) |-> (rc_out_n == pg_out));

endmodule

// File: tb/pwrgood_rst_fanout_test.sv
module pwrgood_rst_fanout_test;
  localparam int U = 100;

  logic clk = 0, rst_n = 0, stby_ok = 0, psu_good = 0, host_rst_n = 0, tick_ms = 0;
  logic [1:0] main_sel = 0, extra_sel = 0;
  logic rc_en = 0, rc_src = 0;
  logic pg_out, rc_out_n;
  logic [4:0] rst_out_n;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwrgood_rst_fanout uut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic idle;
    @(negedge clk);
    stby_ok = 0; psu_good = 0; tick_ms = 0;
    edges(2);
    @(negedge clk);
  endtask

  // Start an attempt with the current settings and check the rise edge exactly.
  task automatic measure(input int tot, input string tag);
    idle();
    stby_ok = 1; psu_good = 1; tick_ms = 1;
    edges(tot - 1);
    chk(pg_out, 0, tag);
    edges(1);
    chk(pg_out, 1, tag);
  endtask

  task automatic t_reset;
    edges(1);
    chk(pg_out, 0, "R2 reset");
    chk(rst_out_n, 5'h00, "R1 reset low");
    chk(rc_out_n, 1, "R8 reset");
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_fanout;
    @(negedge clk); host_rst_n = 1; #1;
    chk(rst_out_n, 5'h1f, "R1 high");
    host_rst_n = 0; #1;
    chk(rst_out_n, 5'h00, "R1 low");
    host_rst_n = 1;
  endtask

  task automatic t_main;
    main_sel = 2'b00; extra_sel = 0; measure(4*U, "R3 sel00");
    main_sel = 2'b01; measure(1*U, "R3 sel01");
    main_sel = 2'b10; measure(2*U, "R3 sel10");
    main_sel = 2'b11; measure(3*U, "R3 sel11");
  endtask

  task automatic t_extra;
    main_sel = 2'b01;
    extra_sel = 2'b01; measure(2*U, "R4 x01");
    extra_sel = 2'b10; measure(3*U, "R4 x10");
    extra_sel = 2'b11; measure(5*U, "R4 x11");
    main_sel = 2'b00; measure(8*U, "R4 max");
    extra_sel = 2'b00;
  endtask

  task automatic t_gaps;
    main_sel = 2'b01;
    idle();
    stby_ok = 1; psu_good = 1; tick_ms = 1;
    edges(50);
    @(negedge clk); tick_ms = 0;
    edges(40);
    chk(pg_out, 0, "R5 gap no count");
    @(negedge clk); tick_ms = 1;
    edges(U - 51);
    chk(pg_out, 0, "R5 before Nth");
    edges(1);
    chk(pg_out, 1, "R5 at Nth");
  endtask

  task automatic t_drop;
    main_sel = 2'b01;
    measure(U, "R6 setup");
    @(negedge clk); psu_good = 0;
    edges(1);
    chk(pg_out, 0, "R6 psu drop");
    @(negedge clk); psu_good = 1;
    edges(U - 1);
    chk(pg_out, 0, "R6 full recount");
    edges(1);
    chk(pg_out, 1, "R6 recount done");
    @(negedge clk); stby_ok = 0;
    edges(1);
    chk(pg_out, 0, "R6 stby drop");
    @(negedge clk); stby_ok = 1;
    edges(U - 10);
    @(negedge clk); stby_ok = 0;
    edges(1);
    @(negedge clk); stby_ok = 1;
    edges(U - 1);
    chk(pg_out, 0, "R6 mid drop restart");
    edges(1);
    chk(pg_out, 1, "R6 mid drop done");
  endtask

  task automatic t_change;
    main_sel = 2'b01; extra_sel = 0;
    idle();
    stby_ok = 1; psu_good = 1; tick_ms = 1;
    edges(20);
    @(negedge clk); main_sel = 2'b00; extra_sel = 2'b11;
    edges(U - 21);
    chk(pg_out, 0, "R7 old total pre");
    edges(1);
    chk(pg_out, 1, "R7 old total kept");
    measure(8*U, "R7 new total next");
    extra_sel = 0;
  endtask

  task automatic t_rc;
    main_sel = 2'b01;
    idle();
    rc_en = 0; host_rst_n = 0; #1;
    chk(rc_out_n, 1, "R8 disabled");
    rc_en = 1; rc_src = 1; #1;
    chk(rc_out_n, 0, "R9 src rst low");
    host_rst_n = 1; #1;
    chk(rc_out_n, 1, "R9 src rst high");
    rc_src = 0; #1;
    chk(rc_out_n, 0, "R9 src pg low");
    stby_ok = 1; psu_good = 1; tick_ms = 1;
    edges(U);
    chk(rc_out_n, 1, "R9 src pg high");
    @(negedge clk); rc_en = 0; stby_ok = 0;
    edges(1);
    chk(rc_out_n, 1, "R8 disabled pg low");
  endtask

  initial begin
    t_reset();
    t_fanout();
    t_main();
    t_extra();
    t_gaps();
    t_drop();
    t_change();
    t_rc();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule